// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder

This block turns the serial transmit line of a host UART into the return-to-zero pulse train that drives an infrared emitter. When a UART bit is zero, the emitter line gives one short high pulse in the middle of that bit. When the bit is one, the line stays dark. Time runs on a bit-clock enable that pulses sixteen times per bit. A falling edge on the UART line starts a frame of ten bit windows: a start bit, eight data bits and a stop bit. After the frame the block waits idle for the next falling edge.

A second enable, the reference tick, comes from a fast fixed-rate source and measures absolute time. Every emitter pulse ends after three bit clocks or after a fixed number of reference ticks, whichever comes first. At low baud rates this keeps the emitter current short. The infrared link is half duplex, so the emitter line is held dark whenever the companion decoder reports that a receive pulse is present. The block runs in the single clock domain `clk`. `bitTick` and `refTick` are single-cycle enables in that domain.

Top module: `sir_pulse_encoder`

## Requirements
- R1: All framing and bit timing moves only on cycles where `bitTick` is high. One bit window is exactly 16 bit ticks, and consecutive windows follow each other with no gap.
- R2: For a zero bit, `txIr` is high for exactly 3 bit ticks. The pulse covers window positions 7, 8 and 9, where position 0 is the window's first tick, and it is low everywhere else in the window.
- R3: For a one bit, `txIr` stays low for all 16 ticks of the window.
- R4: The first pulse of a frame rises on the 7th bit tick after the tick that first samples `txLine` low. That places it 7 to 8 bit clocks after the falling edge itself.
- R5: A pulse also ends as soon as `PULSE_LIMIT` reference ticks have been counted while it is high. The count restarts at every pulse rise, so the emitted width is the shorter of 3 bit clocks and the limit.
- R6: A frame lasts 10 windows, after which the block goes idle. A new frame starts only on a new high-to-low transition of `txLine`. A line that is still low when a frame ends does not start another frame.
- R7: While `rxActive` is high, `txIr` is low in that same cycle, whatever the frame state.
- R8: While `rstN` is low, `txIr` is low and any frame in progress is dropped. After release the block is idle until a new falling edge arrives.
- R9: A window's bit value is the `txLine` level sampled on the bit tick at window position 5. That sample passes through a two-stage synchroniser, so the decision is ready at position 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitTick | input | 1 | Bit-clock enable, 16 per bit |
| refTick | input | 1 | Fixed-rate enable for the pulse-width limiter |
| txLine | input | 1 | Host UART transmit line, idle high |
| rxActive | input | 1 | High while the decoder sees a receive pulse |
| txIr | output | 1 | Emitter drive, high = light |

## Verification
The hardest case to reach is the race between the two pulse terminators. Whether the limiter or the bit clock ends a pulse depends only on how fast reference ticks arrive compared with bit ticks, and that ratio cannot be seen at any output. The stimulus runs the same frames with the reference divider set slow, so the 3-clock width wins, and then set to every cycle, so the limiter wins. Runs of zero bits show that the limiter count restarts on each pulse. Further sequences raise `rxActive` in a fixed cyclic pattern across pulses, send back-to-back frames, hold the line low past a frame's end, and apply reset in the middle of a frame.

// File: rtl/sir_enc_pkg.sv
package sir_enc_pkg;

  // One-cycle strobes from the frame controller to the pulse datapath
  typedef struct packed {
    logic pulseStart;  // begin an emitter pulse, restart limiter
    logic pulseStop;   // end of the nominal pulse window
  } encStrobe_t;

endpackage

// File: rtl/sir_enc_ctrl.sv
module sir_enc_ctrl
  import sir_enc_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int FRAME_BITS    = 10,
  parameter int PULSE_PHASE   = 7,
  parameter int PULSE_TICKS   = 3,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       txSync,
  input  logic       txFall,
  output encStrobe_t strobe
);

  localparam int PW = $clog2(TICKS_PER_BIT);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [PW-1:0] PH_LAST  = PW'(TICKS_PER_BIT - 1);
  localparam logic [PW-1:0] PH_ARM   = PW'(PULSE_PHASE - 1);
  localparam logic [PW-1:0] PH_DROP  = PW'(PULSE_PHASE + PULSE_TICKS - 1);
  // the start edge reaches here SYNC_STAGES ticks late: enter at that phase
  localparam logic [PW-1:0] PH_ENTRY = PW'(SYNC_STAGES);
  localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_BITS - 1);

  typedef enum logic {ST_IDLE, ST_SEND} encState_t;

  encState_t state;
  logic [PW-1:0] phase;
  logic [BW-1:0] bitIdx;

  always_comb begin
    strobe.pulseStart = bitTick && (state == ST_SEND) && (phase == PH_ARM) && !txSync;
    strobe.pulseStop  = bitTick && (state == ST_SEND) && (phase == PH_DROP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= '0;
      bitIdx <= '0;
    end else if (bitTick) begin
      case (state)
        ST_IDLE: begin
          if (txFall) begin
            state  <= ST_SEND;
            phase  <= PH_ENTRY;
            bitIdx <= '0;
          end
        end
        ST_SEND: begin
          if (phase == PH_LAST) begin
            phase <= '0;
            if (bitIdx == BIT_LAST) state <= ST_IDLE;
            else bitIdx <= bitIdx + 1'b1;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sir_enc_dp.sv
module sir_enc_dp
  import sir_enc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_LIMIT = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       refTick,
  input  logic       txLine,
  input  logic       rxActive,
  input  encStrobe_t strobe,
  output logic       txSync,
  output logic       txFall,
  output logic       txIr
);

  localparam int LW = $clog2(PULSE_LIMIT + 1);
  localparam logic [LW-1:0] LIM_LAST = LW'(PULSE_LIMIT - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   txPrev;
  logic                   pulseOn;
  logic                   cutOff;
  logic [LW-1:0]          limCnt;

  // UART line synchroniser, advanced on the bit clock; idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '1;
      txPrev    <= 1'b1;
    end else if (bitTick) begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], txLine};
      txPrev    <= syncChain[SYNC_STAGES-1];
    end
  end

  assign txSync = syncChain[SYNC_STAGES-1];
  assign txFall = txPrev && !txSync;

  // Pulse register with absolute-time limiter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseOn <= 1'b0;
      cutOff  <= 1'b0;
      limCnt  <= '0;
    end else if (strobe.pulseStart) begin
      pulseOn <= 1'b1;
      cutOff  <= 1'b0;
      limCnt  <= '0;
    end else begin
      if (strobe.pulseStop) pulseOn <= 1'b0;
      if (pulseOn && !cutOff && refTick) begin
        limCnt <= limCnt + 1'b1;
        if (limCnt == LIM_LAST) cutOff <= 1'b1;
      end
    end
  end

  assign txIr = pulseOn && !cutOff && !rxActive;

endmodule

// File: rtl/sir_pulse_encoder.sv
module sir_pulse_encoder
  import sir_enc_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int FRAME_BITS    = 10,
  parameter int PULSE_PHASE   = 7,
  parameter int PULSE_TICKS   = 3,
  parameter int SYNC_STAGES   = 2,
  parameter int PULSE_LIMIT   = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitTick,
  input  logic refTick,
  input  logic txLine,
  input  logic rxActive,
  output logic txIr
);

  encStrobe_t strobe;
  logic       txSync;
  logic       txFall;

  sir_enc_ctrl #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .FRAME_BITS   (FRAME_BITS),
    .PULSE_PHASE  (PULSE_PHASE),
    .PULSE_TICKS  (PULSE_TICKS),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .bitTick(bitTick),
    .txSync (txSync),
    .txFall (txFall),
    .strobe (strobe)
  );

  sir_enc_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .PULSE_LIMIT(PULSE_LIMIT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .bitTick (bitTick),
    .refTick (refTick),
    .txLine  (txLine),
    .rxActive(rxActive),
    .strobe  (strobe),
    .txSync  (txSync),
    .txFall  (txFall),
    .txIr    (txIr)
  );

endmodule

// File: rtl/sir_enc_checker.sv
module sir_enc_checker
  import sir_enc_pkg::*;
#(
  parameter int PULSE_LIMIT = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic       bitTick,
  input logic       refTick,
  input logic       rxActive,
  input logic       txIr,
  input encStrobe_t strobe
);

  // reference ticks seen while the emitter has been continuously lit
  int hiRef;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hiRef <= 0;
    else if (!txIr) hiRef <= 0;
    else if (refTick) hiRef <= hiRef + 1;
  end

  AST_RX_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    rxActive |-> !txIr); // R7
  AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pulseStart || strobe.pulseStop) |-> bitTick); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.pulseStart, strobe.pulseStop}) <= 1); // R2
  AST_DROP_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pulseStop |=> !txIr); // R2
  AST_LIMIT_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    hiRef <= PULSE_LIMIT); // R5
  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(txIr) && !$past(rxActive)) |-> $past(bitTick)); // R1

endmodule

bind sir_pulse_encoder sir_enc_checker #(.PULSE_LIMIT(PULSE_LIMIT)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .bitTick (bitTick),
  .refTick (refTick),
  .rxActive(rxActive),
  .txIr    (txIr),
  .strobe  (strobe)
);

// File: tb/sir_pulse_encoder_bench.sv
module sir_pulse_encoder_bench;

  localparam int LIMIT = 8;
  localparam int TICKDIV = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0;
  logic refTick = 1'b0;
  logic txLine = 1'b1;
  logic rxActive = 1'b0;
  logic txIr;

  always #5 clk = ~clk;

  sir_pulse_encoder #(.PULSE_LIMIT(LIMIT)) u_sir_pulse_encoder (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .refTick(refTick),
    .txLine(txLine), .rxActive(rxActive), .txIr(txIr)
  );

  int checks = 0;
  int fails = 0;
  int cycNum = 0;
  int refDiv = 16;
  bit rxPattern = 0;
  string curReq = "R8";
  int riseCount = 0;
  bit prevIr = 0;
  bit finished = 0;

  // behavioural reference
  bit mActive, mPulse, mCut, expIr;
  int mPos, mRef;
  bit hist[$];

  task automatic modelReset();
    mActive = 0; mPulse = 0; mCut = 0; mPos = 0; mRef = 0;
    hist = {1'b1, 1'b1, 1'b1};
  endtask

  task automatic modelStep();
    if (!rstN) begin
      modelReset();
    end else begin
      if (mPulse && !mCut && refTick) begin
        mRef++;
        if (mRef == LIMIT) mCut = 1;
      end
      if (bitTick) begin
        hist.push_front(txLine);
        if (hist.size() > 4) void'(hist.pop_back());
        if (mActive) begin
          mPos++;
          if (mPos == 160) mActive = 0;
          else if (mPos % 16 == 7) begin
            if (hist[2] == 1'b0) begin mPulse = 1; mRef = 0; mCut = 0; end
          end else if (mPos % 16 == 10) mPulse = 0;
        end else if (hist[2] == 1'b0 && hist[3] == 1'b1) begin
          mActive = 1; mPos = 2;
        end
      end
    end
    expIr = mPulse && !mCut && !rxActive;
  endtask

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycNum, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    bitTick  = (cycNum % TICKDIV == 0);
    refTick  = (cycNum % refDiv == 0);
    rxActive = rxPattern && ((cycNum % 7) < 3);
    cycNum++;
    @(posedge clk);
    #2;
    modelStep();
    check(txIr === expIr, curReq, int'(txIr), int'(expIr));
    if (txIr && !prevIr) riseCount++;
    prevIr = txIr;
  endtask

  task automatic sendByte(input logic [7:0] data);
    logic [9:0] frame;
    frame = {1'b1, data, 1'b0};
    for (int b = 0; b < 10; b++) begin
      txLine = frame[b];
      repeat (16 * TICKDIV) cyc();
    end
  endtask

  task automatic idle(input int n);
    txLine = 1'b1;
    repeat (n) cyc();
  endtask

  initial begin
    modelReset();
    // R8: outputs held low in reset
    repeat (10) begin
      @(posedge clk); #2;
      check(txIr === 1'b0, "R8 reset state", int'(txIr), 0);
    end
    rstN = 1'b1;
    idle(40);

    // R2 R3 R4 R9: mixed byte, limiter slower than 3 bit clocks
    curReq = "R2/R3/R4/R9 mixed byte";
    refDiv = 16;
    riseCount = 0;
    sendByte(8'hA5);
    idle(80);
    check(riseCount == 5, "R2/R3 pulse count", riseCount, 5);

    // R5: limiter wins, restarts on every zero bit
    curReq = "R5 limiter";
    refDiv = 1;
    riseCount = 0;
    sendByte(8'h00);
    idle(80);
    check(riseCount == 9, "R5 pulses per zero bit", riseCount, 9);
    refDiv = 2;
    sendByte(8'h81);
    idle(80);

    // R6: back-to-back frames, then a line held low past the frame end
    curReq = "R6 framing";
    refDiv = 16;
    sendByte(8'h3C);
    sendByte(8'hF0);
    txLine = 1'b0;
    riseCount = 0;
    repeat (16 * TICKDIV * 25) cyc();
    check(riseCount == 10, "R6 no restart while low", riseCount, 10);
    idle(200);

    // R7: receive activity blanks the emitter
    curReq = "R7 rx blocking";
    rxPattern = 1;
    sendByte(8'h00);
    sendByte(8'h6B);
    rxPattern = 0;
    idle(80);

    // R8: reset in the middle of a frame
    curReq = "R8 reset abort";
    txLine = 1'b0;
    repeat (200) cyc();
    rstN = 1'b0;
    txLine = 1'b1;
    repeat (8) cyc();
    check(txIr === 1'b0, "R8 reset mid frame", int'(txIr), 0);
    rstN = 1'b1;
    riseCount = 0;
    idle(200);
    check(riseCount == 0, "R8 idle after release", riseCount, 0);
    curReq = "R1/R8 frame after reset";
    sendByte(8'h5A);
    idle(80);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule